// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block keeps the interrupt presentation state of one hardware thread across three privilege rings: the operating-system ring, the hypervisor pool ring and the hypervisor physical ring. Each ring has an 8-bit pending-priority buffer. Two rings drive an interrupt line: the OS ring and the physical ring. Each of these two holds a pending priority, a current priority and a status byte. The pool ring has no line or status of its own. It presents through the physical ring's registers, and a two-bit code in the status byte tells software which of the two hypervisor rings raised the interrupt.

The routing logic sends a present request that carries the ring, the priority and the group level. Software changes the current priority with a write, and it takes an interrupt with an acknowledge strobe. The acknowledge returns the pre-acknowledge status and the new current priority in one 16-bit word. The hypervisor can mark the pool context valid and can pull the pool or physical context away. Each pull re-evaluates the signalling state.

Every request completes in one clock. Outputs are registered and appear after the next rising edge. Only one class of request is taken per cycle, in this order of precedence: pool pull, physical pull, pool push, current-priority write, then acknowledge and present. An acknowledge and a present may share a cycle.

Top module: `ipc_presenter`

## Requirements
- R1: After a synchronous reset, both interrupt lines are low and the acknowledge word is 0x0000. Every current priority is 0, every pending buffer is empty and the pool context is invalid.
- R2: A present with group 0 sets bit (7 - priority) of the target ring's pending buffer. If the priority is numerically below the signalling ring's pending priority, it becomes the new pending priority. The line rises only when that priority is strictly below the current priority.
- R3: A present with group 0 whose priority is not below the current pending priority only records the pending bit. The line and the status byte are left unchanged.
- R4: For the OS ring, the status byte is 0x80 OR the 6-bit group. For the hypervisor rings, bits 7:6 are 2'b10 for the physical ring or 2'b01 for the pool ring, and bits 5:0 hold the group. Pool presents drive the physical line.
- R5: An acknowledge (`ack_phys` 0 selects the OS ring, 1 the physical ring) returns {status before the acknowledge, resulting current priority}. If the status showed an exception, the current priority becomes the pending priority, the status is cleared and the line drops. Otherwise nothing changes. The word holds its value between acknowledges.
- R6: An acknowledge of a group-0 exception clears that priority's pending bit. It clears it in the pool buffer when the status code is 2'b01, and in the ring's own buffer otherwise.
- R7: A current-priority write above 7 is stored as 0xFF.
- R8: A current-priority write recomputes the pending priority as the lowest pending priority in the buffer, or 0xFF if the buffer is empty. The line rises only if the result is strictly below the new current priority; otherwise the status is cleared.
- R9: On the physical ring, a current-priority write also considers the pool buffer, but only while the pool context is valid. When the pool value is strictly lower, the status carries the pool code.
- R10: A present with a non-zero group sets the pending priority directly and leaves the pending buffer untouched.
- R11: A pool pull invalidates the pool context, clears the OS status and re-evaluates the physical ring from its own buffer only.
- R12: A physical pull clears the OS status and the physical status, and lowers both lines.
- R13: When an acknowledge and a present arrive in the same cycle, the acknowledge takes effect first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pres_valid | input | 1 | Present request strobe |
| pres_ring | input | 2 | Ring of the present: 0 OS, 1 pool, 2 physical (3 ignored) |
| pres_prio | input | RW | Priority of the present (0 most urgent) |
| pres_grp | input | RW-2 | Group level of the present (0 = thread-specific) |
| cppr_wr | input | 1 | Current-priority write strobe |
| cppr_phys | input | 1 | Write targets the physical ring (0 = OS ring) |
| cppr_val | input | RW | Current-priority value to write |
| ack_req | input | 1 | Acknowledge strobe |
| ack_phys | input | 1 | Acknowledge targets the physical ring (0 = OS ring) |
| push_pool | input | 1 | Mark the pool context valid |
| pull_pool | input | 1 | Pull the pool context |
| pull_phys | input | 1 | Pull the physical context |
| irq_os | output | 1 | OS-ring interrupt line |
| irq_phys | output | 1 | Physical-ring interrupt line (also carries pool interrupts) |
| ack_word | output | 2*RW | Status before the last acknowledge in the upper byte, current priority in the lower byte |

## Verification
The hardest state to reach from the ports is a physical-ring exception that belongs to the pool ring. Reaching it takes a pending pool bit, a valid pool context and a physical-ring current-priority write that picks the pool value over an empty physical buffer. The stimulus builds this step by step. It then checks that the acknowledge clears the pool bit and not a physical one, by rewriting the priority and observing that no line rises. A second hard case raises a pool exception and pulls the pool context, so that the physical line must come back from the physical buffer alone. An acknowledge and a present in the same cycle are also driven, with priorities chosen so that the two possible orders produce different acknowledge words.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    RING_OS   = 2'd0,
    RING_POOL = 2'd1,
    RING_PHYS = 2'd2
  } ring_e;

  // hypervisor status codes in the two top bits of the status byte
  localparam logic [1:0] HE_POOL = 2'b01;
  localparam logic [1:0] HE_PHYS = 2'b10;
endpackage

// File: rtl/ipc_pipr_enc.sv
module ipc_pipr_enc #(
  parameter int NPRIO = 8,
  parameter int RW    = 8
) (
  input  logic [NPRIO-1:0] ipb,
  output logic [RW-1:0]    pipr
);
  // lowest pending priority wins; bit (NPRIO-1-p) marks priority p
  always_comb begin
    pipr = '1;
    for (int p = NPRIO - 1; p >= 0; p--) begin
      if (ipb[NPRIO-1-p]) pipr = RW'(p);
    end
  end
endmodule

// File: rtl/ipc_ack_dec.sv
module ipc_ack_dec import ipc_pkg::*; #(
  parameter int RW = 8
) (
  input  logic [RW-1:0] nsr,
  input  logic          os_ring,
  output logic          exc,
  output logic          to_pool,
  output logic          grp_zero
);
  localparam int GW = RW - 2;

  assign exc      = os_ring ? nsr[RW-1] : (nsr[RW-1:RW-2] != 2'b00);
  assign to_pool  = !os_ring && (nsr[RW-1:RW-2] == HE_POOL);
  assign grp_zero = (nsr[GW-1:0] == '0);
endmodule

// File: rtl/ipc_presenter.sv
module ipc_presenter import ipc_pkg::*; #(
  parameter int NPRIO = 8,
  parameter int RW    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pres_valid,
  input  logic [1:0]      pres_ring,
  input  logic [RW-1:0]   pres_prio,
  input  logic [RW-3:0]   pres_grp,
  input  logic            cppr_wr,
  input  logic            cppr_phys,
  input  logic [RW-1:0]   cppr_val,
  input  logic            ack_req,
  input  logic            ack_phys,
  input  logic            push_pool,
  input  logic            pull_pool,
  input  logic            pull_phys,
  output logic            irq_os,
  output logic            irq_phys,
  output logic [2*RW-1:0] ack_word
);
  localparam int            NRING    = 3;
  localparam logic [RW-1:0] PRIO_MAX = RW'(NPRIO - 1);
  localparam logic [RW-1:0] NONE     = '1;

  logic [NPRIO-1:0] ipb_q [NRING];
  logic [NPRIO-1:0] n_ipb [NRING];
  logic [RW-1:0]    enc_pipr [NRING];
  logic [RW-1:0]    pipr_os_q, cppr_os_q, nsr_os_q;
  logic [RW-1:0]    pipr_hv_q, cppr_hv_q, nsr_hv_q;
  logic [RW-1:0]    n_pipr_os, n_cppr_os, n_nsr_os;
  logic [RW-1:0]    n_pipr_hv, n_cppr_hv, n_nsr_hv;
  logic             vld_pool_q, n_vld_pool;
  logic [2*RW-1:0]  n_ack;
  logic [RW-1:0]    cv, pm, pp;
  logic [1:0]       code;
  logic             a_exc, a_pool, a_grp0;

  function automatic logic [NPRIO-1:0] prio_mask(input logic [RW-1:0] p);
    prio_mask = '0;
    for (int i = 0; i < NPRIO; i++) begin
      if (p == RW'(i)) prio_mask[NPRIO-1-i] = 1'b1;
    end
  endfunction

  generate
    for (genvar r = 0; r < NRING; r++) begin : g_enc
      ipc_pipr_enc #(.NPRIO(NPRIO), .RW(RW)) u_enc (
        .ipb  (ipb_q[r]),
        .pipr (enc_pipr[r])
      );
    end
  endgenerate

  ipc_ack_dec #(.RW(RW)) u_ack_dec (
    .nsr      (ack_phys ? nsr_hv_q : nsr_os_q),
    .os_ring  (!ack_phys),
    .exc      (a_exc),
    .to_pool  (a_pool),
    .grp_zero (a_grp0)
  );

  always_comb begin
    n_ipb      = ipb_q;
    n_pipr_os  = pipr_os_q;
    n_cppr_os  = cppr_os_q;
    n_nsr_os   = nsr_os_q;
    n_pipr_hv  = pipr_hv_q;
    n_cppr_hv  = cppr_hv_q;
    n_nsr_hv   = nsr_hv_q;
    n_vld_pool = vld_pool_q;
    n_ack      = ack_word;
    cv         = (cppr_val > PRIO_MAX) ? NONE : cppr_val;
    pp         = (pres_prio > PRIO_MAX) ? NONE : pres_prio;
    pm         = enc_pipr[RING_PHYS];
    code       = HE_PHYS;

    if (pull_pool) begin
      n_vld_pool = 1'b0;
      n_nsr_os   = '0;
      n_pipr_hv  = enc_pipr[RING_PHYS];
      n_nsr_hv   = (enc_pipr[RING_PHYS] < cppr_hv_q) ? {HE_PHYS, {(RW-2){1'b0}}} : '0;
    end else if (pull_phys) begin
      n_nsr_os = '0;
      n_nsr_hv = '0;
    end else if (push_pool) begin
      n_vld_pool = 1'b1;
    end else if (cppr_wr) begin
      if (cppr_phys) begin
        n_cppr_hv = cv;
        if (vld_pool_q && (enc_pipr[RING_POOL] < pm)) begin
          pm   = enc_pipr[RING_POOL];
          code = HE_POOL;
        end
        n_pipr_hv = pm;
        n_nsr_hv  = (pm < cv) ? {code, {(RW-2){1'b0}}} : '0;
      end else begin
        n_cppr_os = cv;
        n_pipr_os = enc_pipr[RING_OS];
        n_nsr_os  = (enc_pipr[RING_OS] < cv) ? {2'b10, {(RW-2){1'b0}}} : '0;
      end
    end else begin
      // acknowledge is applied before a present in the same cycle
      if (ack_req) begin
        if (!ack_phys) begin
          if (a_exc) begin
            n_cppr_os = pipr_os_q;
            if (a_grp0) n_ipb[RING_OS] = n_ipb[RING_OS] & ~prio_mask(pipr_os_q);
            n_nsr_os = '0;
          end
          n_ack = {nsr_os_q, n_cppr_os};
        end else begin
          if (a_exc) begin
            n_cppr_hv = pipr_hv_q;
            if (a_grp0) begin
              if (a_pool) n_ipb[RING_POOL] = n_ipb[RING_POOL] & ~prio_mask(pipr_hv_q);
              else        n_ipb[RING_PHYS] = n_ipb[RING_PHYS] & ~prio_mask(pipr_hv_q);
            end
            n_nsr_hv = '0;
          end
          n_ack = {nsr_hv_q, n_cppr_hv};
        end
      end
      if (pres_valid && (pres_ring != 2'd3)) begin
        if (pres_grp == '0) n_ipb[pres_ring] = n_ipb[pres_ring] | prio_mask(pp);
        if (pres_ring == RING_OS) begin
          if ((pres_grp != '0) || (pp < n_pipr_os)) begin
            n_pipr_os = pp;
            n_nsr_os  = (pp < n_cppr_os) ? {2'b10, pres_grp} : '0;
          end
        end else begin
          if ((pres_grp != '0) || (pp < n_pipr_hv)) begin
            code      = (pres_ring == RING_POOL) ? HE_POOL : HE_PHYS;
            n_pipr_hv = pp;
            n_nsr_hv  = (pp < n_cppr_hv) ? {code, pres_grp} : '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NRING; r++) ipb_q[r] <= '0;
      pipr_os_q  <= NONE;
      cppr_os_q  <= '0;
      nsr_os_q   <= '0;
      pipr_hv_q  <= NONE;
      cppr_hv_q  <= '0;
      nsr_hv_q   <= '0;
      vld_pool_q <= 1'b0;
      ack_word   <= '0;
      irq_os     <= 1'b0;
      irq_phys   <= 1'b0;
    end else begin
      ipb_q      <= n_ipb;
      pipr_os_q  <= n_pipr_os;
      cppr_os_q  <= n_cppr_os;
      nsr_os_q   <= n_nsr_os;
      pipr_hv_q  <= n_pipr_hv;
      cppr_hv_q  <= n_cppr_hv;
      nsr_hv_q   <= n_nsr_hv;
      vld_pool_q <= n_vld_pool;
      ack_word   <= n_ack;
      irq_os     <= n_nsr_os[RW-1];
      irq_phys   <= (n_nsr_hv[RW-1:RW-2] != 2'b00);
    end
  end
endmodule

// File: rtl/ipc_presenter_chk.sv
module ipc_presenter_chk #(
  parameter int RW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            pres_valid,
  input logic            cppr_wr,
  input logic            ack_req,
  input logic            ack_phys,
  input logic            push_pool,
  input logic            pull_pool,
  input logic            pull_phys,
  input logic            irq_os,
  input logic            irq_phys,
  input logic [2*RW-1:0] ack_word
);
  logic quiet;
  assign quiet = !pull_pool && !pull_phys && !push_pool && !cppr_wr && !pres_valid;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_os && !irq_phys && ack_word == '0));

  // R5
  ack_os_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_req && !ack_phys && quiet) |=> !irq_os);

  // R5
  ack_hv_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_req && ack_phys && quiet) |=> !irq_phys);

  // R5
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_req |=> $stable(ack_word));

  // R11
  pool_pull_chk: assert property (@(posedge clk) disable iff (rst)
    pull_pool |=> !irq_os);

  // R12
  phys_pull_chk: assert property (@(posedge clk) disable iff (rst)
    (pull_phys && !pull_pool) |=> (!irq_os && !irq_phys));
endmodule

bind ipc_presenter ipc_presenter_chk #(.RW(RW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pres_valid (pres_valid),
  .cppr_wr    (cppr_wr),
  .ack_req    (ack_req),
  .ack_phys   (ack_phys),
  .push_pool  (push_pool),
  .pull_pool  (pull_pool),
  .pull_phys  (pull_phys),
  .irq_os     (irq_os),
  .irq_phys   (irq_phys),
  .ack_word   (ack_word)
);

// File: tb/ipc_presenter_test.sv
module ipc_presenter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pres_valid, cppr_wr, cppr_phys, ack_req, ack_phys;
  logic        push_pool, pull_pool, pull_phys;
  logic [1:0]  pres_ring;
  logic [7:0]  pres_prio, cppr_val;
  logic [5:0]  pres_grp;
  logic        irq_os, irq_phys;
  logic [15:0] ack_word;

  logic [17:0] exp_q [$];
  string       tag_q [$];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;

  always #5 clk = ~clk;

  ipc_presenter uut (
    .clk(clk), .rst(rst),
    .pres_valid(pres_valid), .pres_ring(pres_ring), .pres_prio(pres_prio), .pres_grp(pres_grp),
    .cppr_wr(cppr_wr), .cppr_phys(cppr_phys), .cppr_val(cppr_val),
    .ack_req(ack_req), .ack_phys(ack_phys),
    .push_pool(push_pool), .pull_pool(pull_pool), .pull_phys(pull_phys),
    .irq_os(irq_os), .irq_phys(irq_phys), .ack_word(ack_word)
  );

  task automatic clr();
    pres_valid = 0; pres_ring = 0; pres_prio = 0; pres_grp = 0;
    cppr_wr = 0; cppr_phys = 0; cppr_val = 0;
    ack_req = 0; ack_phys = 0;
    push_pool = 0; pull_pool = 0; pull_phys = 0;
  endtask

  task automatic expect_res(input bit eo, input bit ep, input logic [15:0] ew, input string tag);
    exp_q.push_back({eo, ep, ew});
    tag_q.push_back(tag);
  endtask

  task automatic do_idle(input bit eo, input bit ep, input logic [15:0] ew, input string tag);
    @(negedge clk); clr(); rst = 0;
    expect_res(eo, ep, ew, tag);
  endtask

  task automatic do_pres(input logic [1:0] r, input logic [7:0] p, input logic [5:0] g,
                         input bit eo, input bit ep, input logic [15:0] ew, input string tag);
    @(negedge clk); clr();
    pres_valid = 1; pres_ring = r; pres_prio = p; pres_grp = g;
    expect_res(eo, ep, ew, tag);
  endtask

  task automatic do_cppr(input bit hv, input logic [7:0] v,
                         input bit eo, input bit ep, input logic [15:0] ew, input string tag);
    @(negedge clk); clr();
    cppr_wr = 1; cppr_phys = hv; cppr_val = v;
    expect_res(eo, ep, ew, tag);
  endtask

  task automatic do_ack(input bit hv, input bit eo, input bit ep, input logic [15:0] ew, input string tag);
    @(negedge clk); clr();
    ack_req = 1; ack_phys = hv;
    expect_res(eo, ep, ew, tag);
  endtask

  task automatic do_ack_pres(input bit hv, input logic [1:0] r, input logic [7:0] p,
                             input bit eo, input bit ep, input logic [15:0] ew, input string tag);
    @(negedge clk); clr();
    ack_req = 1; ack_phys = hv;
    pres_valid = 1; pres_ring = r; pres_prio = p; pres_grp = 0;
    expect_res(eo, ep, ew, tag);
  endtask

  task automatic do_ctx(input bit push, input bit ppool, input bit pphys,
                        input bit eo, input bit ep, input logic [15:0] ew, input string tag);
    @(negedge clk); clr();
    push_pool = push; pull_pool = ppool; pull_phys = pphys;
    expect_res(eo, ep, ew, tag);
  endtask

  // monitor: compares one expected item per driven cycle, after the edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if ({irq_os, irq_phys, ack_word} !== e) begin
          n_fail++;
          $display("FAIL %s: got irq_os=%0b irq_phys=%0b ack=%h, expected irq_os=%0b irq_phys=%0b ack=%h",
                   t, irq_os, irq_phys, ack_word, e[17], e[16], e[15:0]);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  localparam bit OS = 1'b0;
  localparam bit HV = 1'b1;

  initial begin
    clr();
    repeat (3) @(negedge clk);
    do_idle(0, 0, 16'h0000, "R1 reset state");
    // OS ring: priority ordering and strict comparison
    do_pres(2'd0, 8'd3, 6'd0, 0, 0, 16'h0000, "R8 no raise while CPPR is 0");
    do_cppr(OS, 8'd5, 1, 0, 16'h0000, "R8 CPPR write raises line");
    do_pres(2'd0, 8'd6, 6'd0, 1, 0, 16'h0000, "R3 worse priority ignored");
    do_pres(2'd0, 8'd1, 6'd0, 1, 0, 16'h0000, "R2 better priority presented");
    do_ack(OS, 0, 0, 16'h8001, "R5 acknowledge with exception");
    do_ack(OS, 0, 0, 16'h0001, "R5 acknowledge without exception");
    do_cppr(OS, 8'd9, 1, 0, 16'h0001, "R7 CPPR above max");
    do_ack(OS, 0, 0, 16'h8003, "R5 acknowledge next pending");
    do_cppr(OS, 8'd6, 0, 0, 16'h8003, "R8 equal priority not signalled");
    do_ack(OS, 0, 0, 16'h0006, "R8 status empty on equality");
    do_cppr(OS, 8'd7, 1, 0, 16'h0006, "R8 strictly better signalled");
    do_ack(OS, 0, 0, 16'h8006, "R5 acknowledge clears last bit");
    do_cppr(OS, 8'd12, 0, 0, 16'h8006, "R7 empty buffer against 0xFF");
    do_ack(OS, 0, 0, 16'h00FF, "R7 CPPR stored as 0xFF");
    // group presents
    do_pres(2'd0, 8'd2, 6'd5, 1, 0, 16'h00FF, "R10 group present signals");
    do_ack(OS, 0, 0, 16'h8502, "R4 OS status carries group");
    do_cppr(OS, 8'd7, 0, 0, 16'h8502, "R10 group left buffer empty");
    do_ack(OS, 0, 0, 16'h0007, "R10 nothing pending");
    // acknowledge and present together
    do_pres(2'd0, 8'd4, 6'd0, 1, 0, 16'h0007, "R2 present raises line");
    do_ack_pres(OS, 2'd0, 8'd2, 1, 0, 16'h8004, "R13 acknowledge applied first");
    do_ack(OS, 0, 0, 16'h8002, "R13 later present still pending");
    // hypervisor rings
    do_pres(2'd2, 8'd4, 6'd0, 0, 0, 16'h8002, "R2 physical present below CPPR 0");
    do_pres(2'd1, 8'd2, 6'd0, 0, 0, 16'h8002, "R4 pool present on physical registers");
    do_cppr(HV, 8'd6, 0, 1, 16'h8002, "R9 invalid pool ignored");
    do_ack(HV, 0, 0, 16'h8004, "R6 physical acknowledge");
    do_ctx(1, 0, 0, 0, 0, 16'h8004, "R9 pool context pushed");
    do_cppr(HV, 8'd6, 0, 1, 16'h8004, "R9 valid pool wins");
    do_ack(HV, 0, 0, 16'h4002, "R6 pool-coded acknowledge");
    do_cppr(HV, 8'd6, 0, 0, 16'h4002, "R6 pool bit cleared");
    // pulls
    do_pres(2'd2, 8'd3, 6'd0, 0, 1, 16'h4002, "R2 physical present raises");
    do_pres(2'd0, 8'd1, 6'd0, 1, 1, 16'h4002, "R2 OS present raises");
    do_pres(2'd1, 8'd0, 6'd0, 1, 1, 16'h4002, "R4 pool present overrides");
    do_ctx(0, 1, 0, 0, 1, 16'h4002, "R11 pool pull re-evaluates physical");
    do_ack(HV, 0, 0, 16'h8003, "R11 status now physical");
    do_cppr(HV, 8'd6, 0, 0, 16'h8003, "R11 pulled pool not counted");
    do_cppr(OS, 8'd7, 1, 0, 16'h8003, "R8 OS pending restored");
    do_pres(2'd2, 8'd2, 6'd0, 1, 1, 16'h8003, "R2 physical present");
    do_ctx(0, 0, 1, 0, 0, 16'h8003, "R12 physical pull lowers both");
    do_ack(HV, 0, 0, 16'h0006, "R12 physical status cleared");
    do_ack(OS, 0, 0, 16'h0007, "R12 OS status cleared");
    do_pres(2'd2, 8'd1, 6'd3, 0, 1, 16'h0007, "R4 hypervisor group present");
    do_ack(HV, 0, 0, 16'h8301, "R4 physical code with group");
    @(negedge clk); clr();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule